// File: doc/BRIEF.md
# I2C Slave Result-Register Readout

This block connects a decoder's result registers to a microcontroller over a two-wire I2C bus. It runs entirely on a fast system clock that oversamples the bus lines. A single control byte can be written to it, which selects the operating mode and which data set is readable. It also serves sequential reads of a bank of seven transfer bytes. The acquisition side offers a new seven-byte result with a one-cycle store request. The block accepts that result only while no bus access to it is in progress. An active-low data-available flag then tells the microcontroller that fresh data waits.

A read always begins with the first transfer byte, most significant bit first. Each byte the master acknowledges advances an internal pointer. A master not-acknowledge makes the slave release the data line. When a read transaction ends, by STOP or by a repeated START, the whole bank returns to all-ones and the data-available flag clears. The bank holds that value until the next accepted store. The data line is open-drain: the block only ever asks for it to be pulled low.

Top module: `regbank_i2c_slave`

## Requirements
- R1: The 7-bit slave address is 0x10 when `sel_hi` is 0 and 0x11 when it is 1, so the address bytes are 0x20/0x21 or 0x22/0x23 (bit 0 = 1 means read). Any other address gets no acknowledge, and the slave never pulls SDA low for it.
- R2: A write transaction carries a single data byte with no sub-address. That byte is acknowledged and copied into the 8-bit control register. Bit 1 of the register is driven on `mode_pdc` and bit 0 on `fmt_sel`. Data bytes after the first are not acknowledged and do not change the register.
- R3: Every read transaction starts at transfer byte 1, which is `store_data[55:48]`. Each byte is sent most significant bit first.
- R4: Each master acknowledge advances the pointer to the next byte, in the order `store_data[55:48]`, `[47:40]`, and so on down to `[7:0]`. After the seventh byte the slave stops driving, so any further byte reads as 0xFF.
- R5: After a master not-acknowledge, the slave keeps SDA released until the next START.
- R6: While the bus is idle, a `store_req` pulse loads all seven bytes and drives `data_avail_n` low. A pulse that arrives while the slave is addressed is dropped, not queued.
- R7: When a read transaction ends, every transfer byte becomes 0xFF and `data_avail_n` goes high.
- R8: After reset, the control register is 0x00, the transfer bytes are 0xFF, `data_avail_n` is 1 and `sda_oe` is 0.
- R9: The slave changes `sda_oe` only while the synchronized SCL is low, or to release the line in response to a START or STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (oversamples the bus) |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Bus clock line as seen at the pad |
| sda_in | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 = pull SDA low (open-drain enable) |
| sel_hi | input | 1 | Address-pair select |
| store_req | input | 1 | One-cycle request to store a new result |
| store_data | input | 56 | New result; byte 1 in bits 55:48 |
| data_avail_n | output | 1 | Low while an unread stored result is held |
| ctrl_q | output | 8 | Control register contents |
| mode_pdc | output | 1 | Control bit 1: operating mode |
| fmt_sel | output | 1 | Control bit 0: data-set select |

## Verification
The case hardest to reach from the ports is a store request that lands in the middle of an addressed read. To test it, the bench stores one result, opens a read, and waits for the address acknowledge. It then pulses `store_req` with a different pattern and reads on. All seven bytes must still match the earlier result, and a later read must return 0xFF, which shows the second pattern was dropped and not held back. A read that runs past the seventh byte, and a not-acknowledge followed by extra SCL pulses, show that the slave lets go of the line at both ends of a read.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_AACK,
        ST_WDATA,
        ST_WACK,
        ST_RLOAD,
        ST_RDATA,
        ST_RACK,
        ST_IGNORE
    } eng_state_t;

    typedef struct packed {
        logic scl;
        logic sda;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } bus_ev_t;

    function automatic logic [6:0] slave_addr(input logic [6:0] base, input logic sel);
        return {base[6:1], sel};
    endfunction

endpackage

// File: rtl/i2cs_bus_sync.sv
module i2cs_bus_sync
    import i2cs_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_in,
    input  logic    sda_in,
    output bus_ev_t ev
);
    logic [SYNC_STAGES-1:0] scl_sr, sda_sr;
    logic scl_d, sda_d;
    logic scl_s, sda_s;

    assign scl_s = scl_sr[SYNC_STAGES-1];
    assign sda_s = sda_sr[SYNC_STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_sr <= '1;
            sda_sr <= '1;
            scl_d  <= 1'b1;
            sda_d  <= 1'b1;
        end else begin
            scl_sr <= {scl_sr[SYNC_STAGES-2:0], scl_in};
            sda_sr <= {sda_sr[SYNC_STAGES-2:0], sda_in};
            scl_d  <= scl_s;
            sda_d  <= sda_s;
        end
    end

    always_comb begin
        ev.scl      = scl_s;
        ev.sda      = sda_s;
        ev.scl_rise = scl_s & ~scl_d;
        ev.scl_fall = ~scl_s & scl_d;
        ev.start    = scl_s & scl_d & sda_d & ~sda_s;
        ev.stop     = scl_s & scl_d & ~sda_d & sda_s;
    end
endmodule

// File: rtl/i2cs_engine.sv
module i2cs_engine
    import i2cs_pkg::*;
#(
    parameter int         NBYTES    = 7,
    parameter logic [6:0] BASE_ADDR = 7'h10,
    localparam int        PTR_W     = $clog2(NBYTES)
) (
    input  logic              clk,
    input  logic              rst,
    input  bus_ev_t           ev,
    input  logic              sel_hi,
    input  logic [BYTE_W-1:0] rd_byte,
    output logic [PTR_W-1:0]  ptr,
    output logic              sda_oe,
    output logic              busy,
    output logic              read_done,
    output logic              ctrl_we,
    output logic [BYTE_W-1:0] ctrl_wdata
);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(NBYTES - 1);

    eng_state_t        state;
    logic [3:0]        cnt;
    logic [BYTE_W-1:0] shreg, txreg;
    logic              rw, mack, rd_txn;

    assign ctrl_wdata = shreg;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;  cnt <= '0;   shreg <= '0;  txreg <= '0;
            ptr <= '0;         sda_oe <= 1'b0; busy <= 1'b0; rd_txn <= 1'b0;
            rw <= 1'b0;        mack <= 1'b0;   read_done <= 1'b0; ctrl_we <= 1'b0;
        end else begin
            read_done <= 1'b0;
            ctrl_we   <= 1'b0;
            if (ev.start || ev.stop) begin
                read_done <= rd_txn;
                rd_txn    <= 1'b0;
                busy      <= 1'b0;
                sda_oe    <= 1'b0;
                ptr       <= '0;
                cnt       <= '0;
                state     <= ev.start ? ST_ADDR : ST_IDLE;
            end else begin
                case (state)
                    ST_ADDR, ST_WDATA: begin
                        if (ev.scl_rise) begin
                            shreg <= {shreg[BYTE_W-2:0], ev.sda};
                            cnt   <= cnt + 4'd1;
                        end else if (ev.scl_fall && cnt == 4'd8) begin
                            if (state == ST_WDATA) begin
                                ctrl_we <= 1'b1;
                                sda_oe  <= 1'b1;
                                state   <= ST_WACK;
                            end else if (shreg[7:1] == slave_addr(BASE_ADDR, sel_hi)) begin
                                sda_oe <= 1'b1;
                                rw     <= shreg[0];
                                busy   <= 1'b1;
                                state  <= ST_AACK;
                            end else begin
                                state <= ST_IGNORE;
                            end
                        end
                    end
                    ST_AACK: if (ev.scl_fall) begin
                        cnt <= '0;
                        if (rw) begin
                            rd_txn <= 1'b1;
                            state  <= ST_RLOAD;
                        end else begin
                            sda_oe <= 1'b0;
                            state  <= ST_WDATA;
                        end
                    end
                    ST_WACK: if (ev.scl_fall) begin
                        sda_oe <= 1'b0;
                        state  <= ST_IGNORE;
                    end
                    ST_RLOAD: begin
                        txreg  <= rd_byte;
                        sda_oe <= ~rd_byte[BYTE_W-1];
                        cnt    <= '0;
                        state  <= ST_RDATA;
                    end
                    ST_RDATA: if (ev.scl_fall) begin
                        if (cnt == 4'd7) begin
                            sda_oe <= 1'b0;
                            state  <= ST_RACK;
                        end else begin
                            txreg  <= txreg << 1;
                            sda_oe <= ~txreg[BYTE_W-2];
                            cnt    <= cnt + 4'd1;
                        end
                    end
                    ST_RACK: begin
                        if (ev.scl_rise) begin
                            mack <= ~ev.sda;
                        end else if (ev.scl_fall) begin
                            if (mack && ptr != LAST) begin
                                ptr   <= ptr + 1'b1;
                                state <= ST_RLOAD;
                            end else begin
                                state <= ST_IGNORE;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // R9: the data line moves only with SCL low, or as a release on START/STOP
    assert_sda_scl_low_R9: assert property (@(posedge clk) disable iff (rst)
        !$stable(sda_oe) |-> (!ev.scl || $past(ev.start || ev.stop)));

    // R4: pointer never passes the last transfer byte
    assert_ptr_bound_R4: assert property (@(posedge clk) disable iff (rst)
        ptr <= LAST);

    // R5: once the slave has stopped taking part, the line stays released
    assert_ignore_released_R5: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IGNORE) |-> !sda_oe);

    // R2: control strobe only after a completed data byte, never while reading
    assert_ctrl_we_write_R2: assert property (@(posedge clk) disable iff (rst)
        ctrl_we |-> (busy && !rd_txn));
endmodule

// File: rtl/i2cs_xfer_bank.sv
module i2cs_xfer_bank
    import i2cs_pkg::*;
#(
    parameter int  NBYTES = 7,
    localparam int PTR_W  = $clog2(NBYTES)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     busy,
    input  logic                     read_done,
    input  logic                     store_req,
    input  logic [NBYTES*BYTE_W-1:0] store_data,
    input  logic [PTR_W-1:0]         rd_ptr,
    output logic [BYTE_W-1:0]        rd_byte,
    output logic                     data_avail_n
);
    logic [NBYTES-1:0][BYTE_W-1:0] bank;
    logic                          take;

    assign take = store_req && !busy && !read_done;

    for (genvar k = 0; k < NBYTES; k++) begin : g_byte
        always_ff @(posedge clk) begin
            if (rst || read_done) begin
                bank[k] <= '1;
            end else if (take) begin
                bank[k] <= store_data[(NBYTES-1-k)*BYTE_W +: BYTE_W];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || read_done) begin
            data_avail_n <= 1'b1;
        end else if (take) begin
            data_avail_n <= 1'b0;
        end
    end

    assign rd_byte = bank[rd_ptr];

    // R6: a store offered during an access leaves the bank untouched
    assert_store_blocked_R6: assert property (@(posedge clk) disable iff (rst)
        (busy && store_req && !read_done) |=> (bank == $past(bank)));

    // R7: end of a read leaves all ones and the flag high
    assert_refill_R7: assert property (@(posedge clk) disable iff (rst)
        read_done |=> (bank == '1 && data_avail_n));
endmodule

// File: rtl/regbank_i2c_slave.sv
module regbank_i2c_slave
    import i2cs_pkg::*;
#(
    parameter int         NBYTES      = 7,
    parameter int         SYNC_STAGES = 2,
    parameter logic [6:0] BASE_ADDR   = 7'h10,
    localparam int        PTR_W       = $clog2(NBYTES)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     scl_in,
    input  logic                     sda_in,
    output logic                     sda_oe,
    input  logic                     sel_hi,
    input  logic                     store_req,
    input  logic [NBYTES*BYTE_W-1:0] store_data,
    output logic                     data_avail_n,
    output logic [BYTE_W-1:0]        ctrl_q,
    output logic                     mode_pdc,
    output logic                     fmt_sel
);
    bus_ev_t           ev;
    logic [PTR_W-1:0]  ptr;
    logic [BYTE_W-1:0] rd_byte, ctrl_wdata;
    logic              busy, read_done, ctrl_we;

    i2cs_bus_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .scl_in(scl_in), .sda_in(sda_in), .ev(ev)
    );

    i2cs_engine #(.NBYTES(NBYTES), .BASE_ADDR(BASE_ADDR)) u_eng (
        .clk(clk), .rst(rst), .ev(ev), .sel_hi(sel_hi), .rd_byte(rd_byte),
        .ptr(ptr), .sda_oe(sda_oe), .busy(busy), .read_done(read_done),
        .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata)
    );

    i2cs_xfer_bank #(.NBYTES(NBYTES)) u_bank (
        .clk(clk), .rst(rst), .busy(busy), .read_done(read_done),
        .store_req(store_req), .store_data(store_data), .rd_ptr(ptr),
        .rd_byte(rd_byte), .data_avail_n(data_avail_n)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (ctrl_we) begin
            ctrl_q <= ctrl_wdata;
        end
    end

    assign mode_pdc = ctrl_q[1];
    assign fmt_sel  = ctrl_q[0];

    // R8: the line is released during reset
    assert_reset_release_R8: assert property (@(posedge clk)
        $past(rst) |-> !sda_oe);
endmodule

// File: tb/tb_regbank_i2c_slave.sv
module tb_regbank_i2c_slave;
    localparam int HP = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        m_scl = 1'b1, m_sda_low = 1'b0;
    logic        sel_hi = 1'b0, store_req = 1'b0;
    logic [55:0] store_data = '0;
    logic        sda_oe, data_avail_n, mode_pdc, fmt_sel;
    logic [7:0]  ctrl_q;
    logic        sda_line;

    int checks = 0, failures = 0;
    logic [7:0] exp_q[$];
    logic [7:0] rx_byte;
    string      rx_tag;
    event       rx_ev;

    always #5 clk = ~clk;
    assign sda_line = ~(m_sda_low | sda_oe);

    regbank_i2c_slave dut (
        .clk(clk), .rst(rst), .scl_in(m_scl), .sda_in(sda_line), .sda_oe(sda_oe),
        .sel_hi(sel_hi), .store_req(store_req), .store_data(store_data),
        .data_avail_n(data_avail_n), .ctrl_q(ctrl_q), .mode_pdc(mode_pdc), .fmt_sel(fmt_sel)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // scoreboard monitor: pops one expected byte per received byte
    always @(rx_ev) begin
        checks++;
        if (exp_q.size() == 0) begin
            failures++;
            $display("FAIL %s actual=%0h expected=<none>", rx_tag, rx_byte);
        end else begin
            logic [7:0] e;
            e = exp_q.pop_front();
            if (rx_byte !== e) begin
                failures++;
                $display("FAIL %s actual=%0h expected=%0h", rx_tag, rx_byte, e);
            end
        end
    end

    task automatic hold(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_bytes(input logic [55:0] d, input int n);
        for (int k = 0; k < n; k++) exp_q.push_back(d[(6-k)*8 +: 8]);
    endtask

    task automatic expect_ff(input int n);
        for (int k = 0; k < n; k++) exp_q.push_back(8'hFF);
    endtask

    task automatic i2c_start();
        hold(2); m_sda_low = 0; hold(2); m_scl = 1; hold(HP);
        m_sda_low = 1; hold(HP); m_scl = 0; hold(HP);
    endtask

    task automatic i2c_stop();
        hold(2); m_sda_low = 1; hold(HP); m_scl = 1; hold(HP);
        m_sda_low = 0; hold(HP);
    endtask

    task automatic write_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            hold(2); m_sda_low = ~b[i]; hold(HP);
            m_scl = 1; hold(HP); m_scl = 0;
        end
        hold(2); m_sda_low = 0; hold(HP);
        m_scl = 1; hold(HP / 2); ack = ~sda_line; hold(HP / 2); m_scl = 0;
    endtask

    task automatic read_byte(input logic give_ack, input string tag);
        logic [7:0] b;
        b = '0;
        m_sda_low = 0;
        for (int i = 0; i < 8; i++) begin
            hold(HP); m_scl = 1; hold(HP / 2); b = {b[6:0], sda_line};
            hold(HP / 2); m_scl = 0;
        end
        hold(2); m_sda_low = give_ack; hold(HP);
        m_scl = 1; hold(HP); m_scl = 0; hold(2); m_sda_low = 0;
        rx_byte = b; rx_tag = tag; ->rx_ev; hold(1);
    endtask

    task automatic read_n(input int n, input string tag);
        for (int i = 0; i < n; i++) read_byte(i < n - 1, tag);
    endtask

    task automatic store(input logic [55:0] d);
        store_data = d; store_req = 1; hold(1); store_req = 0; hold(2);
    endtask

    logic ack;
    int   lows;

    initial begin
        hold(5); rst = 0; hold(3);
        check("R8 ctrl reset", ctrl_q, 8'h00);
        check("R8 avail reset", data_avail_n, 1);
        check("R8 sda released", sda_oe, 0);

        // R8: bank empty after reset reads all ones
        expect_ff(7);
        i2c_start(); write_byte(8'h21, ack); check("R1 ack 0x21", ack, 1);
        read_n(7, "R8 bank reset"); i2c_stop();

        // R6 / R3 / R4: store while idle, read full bank in order
        store(56'h11_22_33_44_55_66_77);
        check("R6 avail low", data_avail_n, 0);
        expect_bytes(56'h11_22_33_44_55_66_77, 7);
        i2c_start(); write_byte(8'h21, ack);
        read_n(7, "R3 R4 ordered read"); i2c_stop(); hold(4);
        check("R7 avail high", data_avail_n, 1);
        expect_ff(7);
        i2c_start(); write_byte(8'h21, ack); read_n(7, "R7 refill"); i2c_stop();

        // R5: NAK on third byte then SCL pulses see released line
        store(56'hA5_5A_C3_3C_0F_F0_81);
        expect_bytes(56'hA5_5A_C3_3C_0F_F0_81, 3);
        i2c_start(); write_byte(8'h21, ack); read_n(3, "R5 short read");
        lows = 0;
        for (int i = 0; i < 9; i++) begin
            hold(HP); m_scl = 1; hold(HP / 2); if (!sda_line) lows++;
            hold(HP / 2); m_scl = 0;
        end
        check("R5 released after nak", lows, 0);
        i2c_stop();
        expect_ff(2);
        i2c_start(); write_byte(8'h21, ack); read_n(2, "R7 after short read"); i2c_stop();

        // R6: store during addressed read is dropped
        store(56'h01_02_03_04_05_06_07);
        i2c_start(); write_byte(8'h21, ack);
        store(56'hDE_AD_BE_EF_12_34_56);
        expect_bytes(56'h01_02_03_04_05_06_07, 7);
        read_n(7, "R6 old data kept"); i2c_stop(); hold(4);
        check("R6 dropped store no flag", data_avail_n, 1);
        expect_ff(7);
        i2c_start(); write_byte(8'h21, ack); read_n(7, "R6 not queued"); i2c_stop();

        // R4: reading past byte seven yields 0xFF
        store(56'h10_20_30_40_50_60_70);
        expect_bytes(56'h10_20_30_40_50_60_70, 7); expect_ff(1);
        i2c_start(); write_byte(8'h21, ack);
        for (int i = 0; i < 8; i++) read_byte(i < 7, "R4 eighth byte");
        i2c_stop();

        // R2: control write, extra byte not accepted
        i2c_start(); write_byte(8'h20, ack); check("R1 ack 0x20", ack, 1);
        write_byte(8'h03, ack); check("R2 data ack", ack, 1);
        write_byte(8'hF0, ack); check("R2 extra byte nak", ack, 0);
        i2c_stop(); hold(2);
        check("R2 ctrl value", ctrl_q, 8'h03);
        check("R2 mode bit", mode_pdc, 1);
        check("R2 fmt bit", fmt_sel, 1);

        // R1: address pair follows sel_hi
        sel_hi = 1;
        i2c_start(); write_byte(8'h20, ack); check("R1 0x20 ignored when high", ack, 0);
        write_byte(8'h00, ack); i2c_stop(); hold(2);
        check("R1 ctrl unchanged", ctrl_q, 8'h03);
        i2c_start(); write_byte(8'h22, ack); check("R1 ack 0x22", ack, 1);
        write_byte(8'h02, ack); i2c_stop(); hold(2);
        check("R2 ctrl second write", ctrl_q, 8'h02);
        check("R2 fmt cleared", fmt_sel, 0);
        i2c_start(); write_byte(8'hA1, ack); check("R1 foreign address", ack, 0);
        i2c_stop();
        store(56'h99_88_77_66_55_44_33);
        expect_bytes(56'h99_88_77_66_55_44_33, 1);
        i2c_start(); write_byte(8'h23, ack); check("R1 ack 0x23", ack, 1);
        read_n(1, "R3 first byte msb first"); i2c_stop();

        // R9 is also covered by the in-design property on every bus edge above
        hold(20);
        check("R9 idle released", sda_oe, 0);
        check("R3 scoreboard drained", exp_q.size(), 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule